// File: doc/BRIEF.md
# Grouped Interrupt Aggregator

The block gathers up to 32 active-high peripheral interrupt sources into one group. Each source has a sticky status bit that sets on a rising edge of the source, and an enable bit. The enabled and pending view of the group is the result vector, the bitwise AND of status and enable. Software reaches the group through a single-cycle synchronous register port with no wait states. Writes take effect at the clock edge and read data is returned in the same cycle.

A run-time mode input selects how the result reaches the processor's interrupt controller. In per-source mode each result bit drives its own line. In aggregated mode all result bits are ORed onto one group line. Enables are never written as a whole word. One register turns selected enables on and another turns selected enables off, so software never needs a read-modify-write sequence that could race.

Register offsets (byte addresses, 4-bit bus address): 0x0 status (read, write 1 to clear), 0x4 enable-set (write 1 to set; reads return the enable vector), 0x8 result (read-only), 0xC enable-clear (write 1 to clear; reads return the enable vector). All other offsets read zero and ignore writes.

Top module: `irq_group_agg`

## Requirements
- R1: After reset, status and enable are all zeros, every offset reads zero, and both output kinds are 0.
- R2: A status bit sets on a clock edge where its source is sampled 1 after having been sampled 0. A source held high does not set the bit again after it is cleared.
- R3: Writing offset 0x0 clears each status bit written with 1. Bits written with 0 keep their value. Reading 0x0 returns status.
- R4: Writing offset 0x4 sets each enable bit written with 1. Bits written with 0 are unchanged.
- R5: Writing offset 0xC clears each enable bit written with 1. Bits written with 0 are unchanged.
- R6: Reading 0x8 returns status AND enable. Writes to 0x8 change neither status nor enable.
- R7: With the mode input at 1 (per-source), output line i equals result bit i, and the group line is 0.
- R8: With the mode input at 0 (aggregated), the group line is the OR of all result bits, and every per-source line is 0.
- R9: A source rising edge in the same cycle as a write-1-to-clear of its status bit leaves the bit at 1.
- R10: Reads of 0x4 and 0xC return the enable vector. Reads of any other unused offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Active-high interrupt sources |
| direct_mode_i | input | 1 | 1 selects per-source outputs, 0 selects the group line |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | 4 | Byte offset within the bank |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Read data, valid in the access cycle |
| src_irq_o | output | NUM_SRC | Per-source interrupt lines |
| grp_irq_o | output | 1 | Aggregated group interrupt line |

## Verification
On every cycle the assertions check four things: edge-set priority over clearing, the write-1-to-clear and hold behaviour of status, the set and clear behaviour of enable, and the mutual exclusion of the two output kinds together with the value each carries. Only the bench scenarios can show certain other behaviour. These include whether a held-high source stays cleared, whether writes of zeros and writes to the result offset leave state untouched, and whether every offset, including unused ones, reads back the expected word. The bench does this by comparing against a model across long random bus traffic and mode switches.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_RESULT = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 4'hC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_EN_SET, SEL_RESULT, SEL_EN_CLR
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_STATUS: return SEL_STATUS;
      OFF_EN_SET: return SEL_EN_SET;
      OFF_RESULT: return SEL_RESULT;
      OFF_EN_CLR: return SEL_EN_CLR;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] w1c_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      status_o <= '0;
    end else begin
      src_q    <= src_i;
      status_o <= (status_o & ~w1c_i) | rise; // set beats clear
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((status_o & $past(rise)) == $past(rise)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((w1c_i & ~rise) != '0) |=> ((status_o & $past(w1c_i & ~rise)) == '0));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~w1c_i) != '0) |=>
      ((status_o & $past(status_o & ~w1c_i)) == $past(status_o & ~w1c_i)));
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else         en_o <= (en_o | set_i) & ~clr_i;
  end

  assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & ~clr_i) != '0) |=> ((en_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((en_o & $past(clr_i)) == '0));

  assert_untouched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i | clr_i) == '0) |=> $stable(en_o));
endmodule

// File: rtl/irq_out_route.sv
module irq_out_route #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               direct_i,
  input  logic [NUM_SRC-1:0] result_i,
  output logic [NUM_SRC-1:0] src_irq_o,
  output logic               grp_irq_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_line
      assign src_irq_o[g] = direct_i & result_i[g];
    end
  endgenerate
  assign grp_irq_o = ~direct_i & (|result_i);
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               direct_mode_i,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [3:0]         bus_addr_i,
  input  logic [NUM_SRC-1:0] bus_wdata_i,
  output logic [NUM_SRC-1:0] bus_rdata_o,
  output logic [NUM_SRC-1:0] src_irq_o,
  output logic               grp_irq_o
);
  reg_sel_e           sel;
  logic               wr;
  logic [NUM_SRC-1:0] w1c_status, en_set, en_clr;
  logic [NUM_SRC-1:0] status, enable, result;

  assign sel = decode_off(bus_addr_i);
  assign wr  = bus_en_i & bus_we_i;

  assign w1c_status = (wr && sel == SEL_STATUS) ? bus_wdata_i : '0;
  assign en_set     = (wr && sel == SEL_EN_SET) ? bus_wdata_i : '0;
  assign en_clr     = (wr && sel == SEL_EN_CLR) ? bus_wdata_i : '0;

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i),
    .w1c_i(w1c_status), .status_o(status)
  );

  irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set),
    .clr_i(en_clr), .en_o(enable)
  );

  assign result = status & enable;

  always_comb begin
    unique case (sel)
      SEL_STATUS:             bus_rdata_o = status;
      SEL_EN_SET, SEL_EN_CLR: bus_rdata_o = enable;
      SEL_RESULT:             bus_rdata_o = result;
      default:                bus_rdata_o = '0;
    endcase
  end

  irq_out_route #(.NUM_SRC(NUM_SRC)) u_route (
    .direct_i(direct_mode_i), .result_i(result),
    .src_irq_o(src_irq_o), .grp_irq_o(grp_irq_o)
  );

  assert_direct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_mode_i |-> (!grp_irq_o && src_irq_o == (status & enable)));

  assert_aggr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !direct_mode_i |-> (src_irq_o == '0 && grp_irq_o == ((status & enable) != '0)));

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_irq_o && (src_irq_o != '0)));
endmodule

// File: tb/sim_irq_group_agg.sv
`timescale 1ns/1ps
module sim_irq_group_agg;
  localparam int N = 32;
  logic clk = 0, rst_ni = 0;
  logic [N-1:0] src = '0, wdata = '0;
  logic direct = 0, en = 0, we = 0;
  logic [3:0] addr = '0;
  logic [N-1:0] rdata, src_irq;
  logic grp_irq;

  int checks = 0, errors = 0;
  logic [N-1:0] m_stat = '0, m_en = '0, m_prev = '0, last_rd;

  irq_group_agg #(.NUM_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .direct_mode_i(direct),
    .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .src_irq_o(src_irq), .grp_irq_o(grp_irq));

  always #10 clk = ~clk;

  function automatic logic [N-1:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_stat;
      4'h4, 4'hC: return m_en;
      4'h8: return m_stat & m_en;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at negedge; returns at next negedge
  task automatic cyc(input logic [N-1:0] s, input logic d, input logic e,
                     input logic w, input logic [3:0] a, input logic [N-1:0] wd);
    logic [N-1:0] rise, c;
    src = s; direct = d; en = e; we = w; addr = a; wdata = wd;
    #4;
    last_rd = rdata;
    if (e && !w) chk((a == 4'h0) ? "R3" : (a == 4'h8) ? "R6" : "R10", rdata, exp_read(a));
    if (d) begin
      chk("R7", src_irq, m_stat & m_en);
      chk("R7", {31'b0, grp_irq}, '0);
    end else begin
      chk("R8", src_irq, '0);
      chk("R8", {31'b0, grp_irq}, {31'b0, |(m_stat & m_en)});
    end
    @(posedge clk);
    rise = s & ~m_prev;
    c = (e && w && a == 4'h0) ? wd : '0;
    m_stat = (m_stat & ~c) | rise;
    if (e && w && a == 4'h4) m_en = m_en | wd;
    if (e && w && a == 4'hC) m_en = m_en & ~wd;
    m_prev = s;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(src, direct, 1'b1, 1'b0, a, '0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state
    chk("R1", src_irq, '0); chk("R1", {31'b0, grp_irq}, '0);
    rd(4'h0); chk("R1", last_rd, '0);
    rd(4'h4); chk("R1", last_rd, '0);
    rd(4'h8); chk("R1", last_rd, '0);
    rd(4'h5); chk("R10", last_rd, '0);
    // R4 / R10
    cyc('0, 1, 1, 1, 4'h4, 32'h0000_00F5);
    cyc('0, 1, 1, 1, 4'h4, 32'h0);
    rd(4'h4); chk("R4", last_rd, 32'h0000_00F5);
    rd(4'hC); chk("R10", last_rd, 32'h0000_00F5);
    // R5
    cyc('0, 1, 1, 1, 4'hC, 32'h0000_0005);
    rd(4'hC); chk("R5", last_rd, 32'h0000_00F0);
    cyc('0, 1, 1, 1, 4'h4, 32'h0000_000F);
    // R2: held-high source
    cyc(32'h1, 1, 0, 0, 4'h0, '0);
    rd(4'h0); chk("R2", last_rd, 32'h1);
    cyc(32'h1, 1, 1, 1, 4'h0, 32'h1);
    cyc(32'h1, 1, 0, 0, 4'h0, '0);
    rd(4'h0); chk("R2", last_rd, 32'h0);
    // R9: set wins over clear
    cyc(32'h3, 0, 0, 0, 4'h0, '0);
    cyc(32'h1, 0, 0, 0, 4'h0, '0);
    cyc(32'h3, 0, 1, 1, 4'h0, 32'h2);
    rd(4'h0); chk("R9", last_rd, 32'h2);
    // R3: zeros have no effect
    cyc(32'h3, 0, 1, 1, 4'h0, 32'h0);
    rd(4'h0); chk("R3", last_rd, 32'h2);
    // R6: write to result ignored
    cyc(32'h3, 1, 1, 1, 4'h8, 32'hFFFF_FFFF);
    rd(4'h8); chk("R6", last_rd, 32'h2);
    rd(4'h4); chk("R6", last_rd, 32'h0000_00FF);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] s, wd;
      logic [3:0] a;
      s  = ($urandom % 4 == 0) ? $urandom : src;
      wd = ($urandom % 2) ? $urandom : (32'h1 << ($urandom % 32));
      a  = ($urandom % 3 == 0) ? 4'($urandom) : {2'($urandom), 2'b00};
      cyc(s, ($urandom % 8 == 0) ? ~direct : direct, 1'($urandom), 1'($urandom), a, wd);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule